// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a cache and the next memory level and holds block writes that the cache has sent out but memory has not yet taken. Each entry stores one block address, the block's word data and one valid bit per word. A later write to a block that already has an entry merges into that entry, so repeated word stores to one block reach memory as a single transfer. Entries leave oldest first whenever the memory port is free.

A read miss from the cache is compared against every held entry. When nothing matches, the read takes the memory port ahead of the queued writes, so a dirty victim can be parked in the buffer and the missing block fetched before the victim is written. When an entry matches, the read waits until every entry holding that block has drained, which keeps read-after-write order. The requester is released as soon as its read data returns, whether or not the buffer is empty.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `buf_empty`=1, `buf_full`=0, `wr_ready`=1 and `mem_req`=0.
- R2: A write whose block address matches an entry that is not currently offered to memory merges into it: the entry's word mask becomes the OR of both masks, words selected by the new mask (bit w selects data bits [w*WW +: WW]) take the new data, and only one memory write results.
- R3: A write to the block in the oldest entry while that entry is offered to memory opens a new entry instead of merging, and both entries later drain as separate writes.
- R4: With DEPTH entries held, a write with no merge target sees `wr_ready`=0 and waits; one cycle after an entry drains, `wr_ready` returns to 1 and the write is taken. A merging write is accepted even when full.
- R5: Writes reach memory in the order their entries were opened, each with `mem_we`=1, `mem_wmask` equal to the accumulated word mask, and the offered address, mask and data unchanged until `mem_ack`.
- R6: `rd_hit` is 1 while `rd_req` is high and the read block address equals the address of a held entry or of a write presented in the same cycle.
- R7: A read that hits is not sent to memory; it is issued (with `mem_we`=0) once no entry holds its block, after the matching writes.
- R8: A read that does not hit is issued before any queued write; when a read and a drain compete for the port in one cycle, the read takes it.
- R9: `rd_done` pulses with `rd_data` for the issued read when memory returns data, while writes may still be queued.
- R10: `buf_full` is 1 exactly when DEPTH entries are held and `buf_empty` is 1 exactly when none are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Cache offers a block write |
| wr_ready | output | 1 | Buffer accepts the offered write this cycle |
| wr_addr | input | AW | Block address of the write |
| wr_mask | input | WORDS | Words of the write that carry data |
| wr_data | input | WORDS*WW | Block data, word w at bits w*WW |
| rd_req | input | 1 | Read miss request, held until rd_done |
| rd_addr | input | AW | Block address of the read |
| rd_hit | output | 1 | Read address matches buffered or incoming write |
| rd_done | output | 1 | Read data returned this cycle |
| rd_data | output | WORDS*WW | Returned block data |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | 1 for a buffered write, 0 for a read |
| mem_addr | output | AW | Block address to memory |
| mem_wmask | output | WORDS | Words to write |
| mem_wdata | output | WORDS*WW | Write data |
| mem_ack | input | 1 | Memory takes the request this cycle |
| mem_rvalid | input | 1 | Memory returns read data |
| mem_rdata | input | WORDS*WW | Read data from memory |
| buf_full | output | 1 | All entries held |
| buf_empty | output | 1 | No entry held |

## Verification
A lost merge or a wrong mask shows at the memory port on the drain of that entry, as a wrong `mem_wmask` or as two writes where one was due, and later as stale words in the read data of that block. A wrong match result shows within one cycle as `rd_hit` or as a read that appears in the memory transaction order before the write it depends on. A bad entry count shows at once in the flags and in `wr_ready`, and as a missing or extra drain when the buffer empties.

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int AW    = 8,
  parameter int WORDS = 4,
  parameter int WW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [AW-1:0]       wr_addr,
  input  logic [WORDS-1:0]    wr_mask,
  input  logic [WORDS*WW-1:0] wr_data,
  input  logic                rd_req,
  input  logic [AW-1:0]       rd_addr,
  output logic                rd_hit,
  output logic                rd_done,
  output logic [WORDS*WW-1:0] rd_data,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [WORDS-1:0]    mem_wmask,
  output logic [WORDS*WW-1:0] mem_wdata,
  input  logic                mem_ack,
  input  logic                mem_rvalid,
  input  logic [WORDS*WW-1:0] mem_rdata,
  output logic                buf_full,
  output logic                buf_empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]    e_vld;
  logic [AW-1:0]       e_addr [DEPTH];
  logic [WORDS-1:0]    e_mask [DEPTH];
  logic [WORDS*WW-1:0] e_data [DEPTH];
  logic [PW-1:0]       head, tail, merge_idx;
  logic [CW-1:0]       cnt;
  logic                rd_busy;
  logic [DEPTH-1:0]    hit_vec, mv;

  assign buf_empty = (cnt == '0);
  assign buf_full  = (cnt == CW'(DEPTH));

  always_comb begin
    merge_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_vec[i] = e_vld[i] && (e_addr[i] == rd_addr);
      mv[i] = e_vld[i] && (e_addr[i] == wr_addr) && !(drain_offer && PW'(i) == head);
      if (mv[i]) merge_idx = PW'(i);
    end
  end

  logic rd_go, drain_offer, drain_fire, rd_fire, wr_fire, merge_hit, alloc;
  assign rd_hit      = rd_req && ((|hit_vec) || (wr_valid && wr_addr == rd_addr));
  assign rd_go       = rd_req && !rd_hit && !rd_busy;
  assign drain_offer = !rd_go && !buf_empty;
  assign mem_req     = rd_go || drain_offer;
  assign mem_we      = drain_offer;
  assign mem_addr    = rd_go ? rd_addr : e_addr[head];
  assign mem_wmask   = e_mask[head];
  assign mem_wdata   = e_data[head];
  assign drain_fire  = drain_offer && mem_ack;
  assign rd_fire     = rd_go && mem_ack;
  assign merge_hit   = |mv;
  assign wr_ready    = merge_hit || !buf_full;
  assign wr_fire     = wr_valid && wr_ready;
  assign alloc       = wr_fire && !merge_hit;
  assign rd_done     = rd_busy && mem_rvalid;
  assign rd_data     = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld   <= '0;
      head    <= '0;
      tail    <= '0;
      cnt     <= '0;
      rd_busy <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        e_addr[i] <= '0;
        e_mask[i] <= '0;
        e_data[i] <= '0;
      end
    end else begin
      if (wr_fire && merge_hit) begin
        e_mask[merge_idx] <= e_mask[merge_idx] | wr_mask;
        for (int w = 0; w < WORDS; w++)
          if (wr_mask[w]) e_data[merge_idx][w*WW +: WW] <= wr_data[w*WW +: WW];
      end
      if (alloc) begin
        e_vld[tail]  <= 1'b1;
        e_addr[tail] <= wr_addr;
        e_mask[tail] <= wr_mask;
        e_data[tail] <= wr_data;
        tail <= (tail == PW'(DEPTH - 1)) ? '0 : tail + 1'b1;
      end
      if (drain_fire) begin
        e_vld[head] <= 1'b0;
        head <= (head == PW'(DEPTH - 1)) ? '0 : head + 1'b1;
      end
      cnt <= cnt + CW'(alloc) - CW'(drain_fire);
      if (rd_fire) rd_busy <= 1'b1;
      else if (mem_rvalid) rd_busy <= 1'b0;
    end
  end

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_full && buf_empty));
  a_r4_ready_with_room: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_full |-> wr_ready);
  a_r7_no_read_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (hit_vec == '0));
  a_r8_miss_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_hit && !rd_busy) |-> (mem_req && !mem_we));
  a_r5_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack) |=>
      (!mem_we || ($stable(mem_addr) && $stable(mem_wmask) && $stable(mem_wdata))));
endmodule

// File: tb/sim_merge_wbuf.sv
module sim_merge_wbuf;
  localparam int CLK_P = 10;
  localparam int AW = 8, WORDS = 4, WW = 16, DEPTH = 4;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_req = 0, wack = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [WORDS-1:0] wr_mask = 0;
  logic [WORDS*WW-1:0] wr_data = 0;
  logic wr_ready, rd_hit, rd_done, mem_req, mem_we, mem_ack, mem_rvalid, buf_full, buf_empty;
  logic [AW-1:0] mem_addr;
  logic [WORDS-1:0] mem_wmask;
  logic [WORDS*WW-1:0] rd_data, mem_wdata, mem_rdata;

  int errors = 0, checks = 0;
  always #(CLK_P/2) clk = ~clk;

  merge_wbuf #(.AW(AW), .WORDS(WORDS), .WW(WW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_mask(wr_mask), .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr), .rd_hit(rd_hit),
    .rd_done(rd_done), .rd_data(rd_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wmask(mem_wmask), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .buf_full(buf_full), .buf_empty(buf_empty));

  // memory model: reads taken at once, data after LAT cycles; writes taken when wack
  logic [15:0] bmem [256][4];
  logic pend;
  logic [1:0] lat;
  logic [AW-1:0] rad;
  logic log_we [64];
  logic [AW-1:0] log_addr [64];
  logic [WORDS-1:0] log_mask [64];
  logic [WORDS*WW-1:0] log_data [64];
  int n_log;

  assign mem_ack = mem_we ? wack : 1'b1;
  assign mem_rvalid = pend && lat == 0;
  always_comb for (int w = 0; w < WORDS; w++) mem_rdata[w*WW +: WW] = bmem[rad][w];

  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 0; lat <= 0; rad <= 0; n_log <= 0;
      for (int a = 0; a < 256; a++)
        for (int w = 0; w < 4; w++) bmem[a][w] <= {a[7:0], 4'hE, w[3:0]};
    end else begin
      if (mem_req && mem_ack) begin
        log_we[n_log] <= mem_we; log_addr[n_log] <= mem_addr;
        log_mask[n_log] <= mem_wmask; log_data[n_log] <= mem_wdata;
        n_log <= n_log + 1;
        if (mem_we) begin
          for (int w = 0; w < WORDS; w++)
            if (mem_wmask[w]) bmem[mem_addr][w] <= mem_wdata[w*WW +: WW];
        end else begin
          pend <= 1; lat <= 2'(LAT); rad <= mem_addr;
        end
      end else if (pend && lat != 0) lat <= lat - 1;
      if (mem_rvalid) pend <= 0;
    end
  end

  function automatic logic [WORDS*WW-1:0] blk(input logic [7:0] a, input logic [3:0] s);
    for (int w = 0; w < WORDS; w++) blk[w*WW +: WW] = {a, s, w[3:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic put(input logic [7:0] a, input logic [3:0] m, input logic [3:0] s);
    wr_valid = 1; wr_addr = a; wr_mask = m; wr_data = blk(a, s);
  endtask

  task automatic wait_done();
    for (int k = 0; k < 100 && !rd_done; k++) tick();
  endtask

  task automatic wait_empty();
    for (int k = 0; k < 100 && !buf_empty; k++) tick();
  endtask

  // {addr, mask, expected wr_ready, expected full after}
  localparam logic [13:0] VEC [7] = '{
    {8'h10, 4'b0001, 1'b1, 1'b0},
    {8'h20, 4'b0010, 1'b1, 1'b0},
    {8'h20, 4'b1000, 1'b1, 1'b0},
    {8'h30, 4'b0100, 1'b1, 1'b0},
    {8'h10, 4'b0100, 1'b1, 1'b1},
    {8'h50, 4'b0001, 1'b0, 1'b1},
    {8'h30, 4'b0001, 1'b1, 1'b1}};

  initial begin
    #(CLK_P * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 empty", buf_empty, 1); check("R1 full", buf_full, 0);
    check("R1 ready", wr_ready, 1);  check("R1 mem_req", mem_req, 0);
    @(negedge clk);

    // table: merges, head-offered split, full stall (writes not acked)
    for (int i = 0; i < 7; i++) begin
      put(VEC[i][13:6], VEC[i][5:2], 4'(i + 1));
      #1 check($sformatf("R4 ready step %0d", i + 1), wr_ready, VEC[i][1]);
      tick();
      wr_valid = 0;
      check($sformatf("R10 full step %0d", i + 1), buf_full, VEC[i][0]);
      check($sformatf("R10 empty step %0d", i + 1), buf_empty, 0);
    end

    // hit read waits behind matching entry
    rd_req = 1; rd_addr = 8'h30;
    #1 check("R6 hit", rd_hit, 1);
    check("R7 write offered not read", mem_we, 1);
    wack = 1;
    wait_done();
    check("R9 done", rd_done, 1);
    check("R7 read data w0", rd_data[15:0], {8'h30, 4'd7, 4'd0});
    check("R7 read data w1", rd_data[31:16], 16'h30E1);
    check("R7 read data w2", rd_data[47:32], {8'h30, 4'd4, 4'd2});
    tick(); rd_req = 0;
    wait_empty();
    check("R5 log count", n_log, 5);
    check("R5 t0", {log_we[0], log_addr[0], log_mask[0]}, {1'b1, 8'h10, 4'b0001});
    check("R2 t1 merged mask", {log_we[1], log_addr[1], log_mask[1]}, {1'b1, 8'h20, 4'b1010});
    check("R2 t1 word3", log_data[1][63:48], {8'h20, 4'd3, 4'd3});
    check("R2 t1 word1", log_data[1][31:16], {8'h20, 4'd2, 4'd1});
    check("R2 t2 merged mask", {log_we[2], log_addr[2], log_mask[2]}, {1'b1, 8'h30, 4'b0101});
    check("R7 t3 read after match", {log_we[3], log_addr[3]}, {1'b0, 8'h30});
    check("R3 t4 split entry", {log_we[4], log_addr[4], log_mask[4]}, {1'b1, 8'h10, 4'b0100});

    // miss read bypasses parked victim
    wack = 0; base = n_log;
    put(8'h60, 4'b1111, 4'd8); tick(); wr_valid = 0;
    rd_req = 1; rd_addr = 8'h70;
    #1 check("R6 miss", rd_hit, 0);
    check("R8 read wins port", {mem_req, mem_we, mem_addr}, {1'b1, 1'b0, 8'h70});
    wait_done();
    check("R9 released with write queued", buf_empty, 0);
    check("R9 read data", rd_data[15:0], 16'h70E0);
    tick(); rd_req = 0;
    wack = 1; wait_empty();
    check("R8 read before victim", {log_we[base], log_addr[base]}, {1'b0, 8'h70});
    check("R8 victim after", {log_we[base+1], log_addr[base+1], log_mask[base+1]}, {1'b1, 8'h60, 4'b1111});

    // same-cycle incoming write counts as a hit
    base = n_log;
    put(8'hA0, 4'b0010, 4'd9); rd_req = 1; rd_addr = 8'hA0;
    #1 check("R6 incoming write hit", rd_hit, 1);
    tick(); wr_valid = 0;
    wait_done(); tick(); rd_req = 0;
    check("R7 write first", {log_we[base], log_addr[base]}, {1'b1, 8'hA0});
    check("R7 then read", {log_we[base+1], log_addr[base+1]}, {1'b0, 8'hA0});

    // stall release once an entry drains
    wack = 0; base = n_log;
    for (int i = 0; i < 4; i++) begin put(8'h90 + 8'(i), 4'b0001, 4'(i)); tick(); end
    put(8'h94, 4'b0001, 4'd5);
    #1 check("R4 stalled", wr_ready, 0);
    wack = 1; tick();
    check("R4 released", wr_ready, 1);
    tick(); wr_valid = 0;
    wait_empty();
    check("R5 drained count", n_log - base, 5);
    for (int i = 0; i < 5; i++)
      check($sformatf("R5 order %0d", i), log_addr[base+i], 8'h90 + 8'(i));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule